// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from one asynchronous serial line. A clock enable pulsing at sixteen times the bit rate paces it. On every such tick the receiver looks at the line. It finds and qualifies a start bit, then takes a value for each bit by a three-sample vote in the middle of the bit. Any disagreement inside that vote is recorded as noise. It collects eight or nine data bits, least significant first, followed by one stop bit.

When a character is complete, its data goes into a read-only holding register along with four status flags: data ready, noise, framing error and overrun. When the data-ready flag is set and interrupts are enabled, the block raises an interrupt request. Software clears the flags by reading status and then reading data. A low receiver enable keeps the whole block idle and cleared. The line input is taken to be synchronous to `clk`.

Top module: `uart_os_rx`

## Requirements
- R1: With `len9` low, a character carries 8 data bits; with `len9` high it carries 9. The length is latched on the tick that detects the start bit.
- R2: Data bits arrive least significant first. In 9-bit mode the ninth bit (bit index 8) is presented on `rx_bit8` and the low eight bits on `rx_data`. In 8-bit mode `rx_bit8` is loaded with 0.
- R3: `rx_data`, `rx_bit8` and `rx_full` change only in the clock after the tick that takes the 16th sample of the stop bit. That edge sets `rx_full`.
- R4: A start bit is detected on the first tick that sees the line low, and that tick counts as sample 1. Every bit spans 16 ticks, and its value is the majority of samples 8, 9 and 10. Samples outside 8..10 do not affect the value or the noise flag.
- R5: If samples 8, 9 and 10 of any bit of a character (start, data or stop) are not all equal, `rx_noise` is loaded high with that character.
- R6: `rx_noise` rises on the same clock edge as `rx_full` for the character that carried the noise.
- R7: A start bit whose vote reads high is a false start. The receiver returns to hunting for a start bit and no register or flag changes.
- R8: A stop bit whose vote reads low loads `rx_ferr` high with the character.
- R9: If a character completes while `rx_full` is set and no clearing read happens in that cycle, `rx_ovr` is set. The held data, ninth bit, noise and framing flags are kept.
- R10: A `data_rd` pulse clears `rx_full`, `rx_noise`, `rx_ferr` and `rx_ovr` only after a `stat_rd` pulse has been seen since the last `data_rd`. A `data_rd` alone has no effect. If the clearing read falls in the cycle a character completes, the new character is loaded, `rx_full` stays set and `rx_ovr` is 0.
- R11: `rx_irq` is high exactly when `rx_full` and `irq_en` are both high.
- R12: While `rx_en` is low, the receiver ignores the line and all flags, the held data and the read sequence are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| len9 | input | 1 | Character length select: 0 = 8 bits, 1 = 9 bits |
| irq_en | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | Status read strobe (arms clearing) |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | DATA_W | Held character data |
| rx_bit8 | output | 1 | Held ninth data bit |
| rx_full | output | 1 | Data-ready flag |
| rx_noise | output | 1 | Noise flag |
| rx_ferr | output | 1 | Framing-error flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Character completion and the clearing data read can land in the same clock. The bench provokes this in two steps. It first leaves a character held and overrun, then arms the clear with a status read. It then pulses `data_rd` on the very tick that takes the 16th stop-bit sample of the next character. The expected result is that the new character is held, `rx_full` stays set, and overrun and the old flags are gone. The bench's behavioural model computes the same outcome each clock from its own queue of samples, so both an early clear and a missed load show up as mismatches.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } rx_phase_t;

  // majority of three mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // any disagreement among the three mid-bit samples
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler
  import uart_os_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int MID = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic line,
  input  logic busy,
  input  logic start_det,
  output logic bit_end,
  output logic bit_val,
  output logic bit_noisy
);

  localparam int CW = $clog2(OSR + 1);
  localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] S_MID = CW'(MID);
  localparam logic [CW-1:0] S_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] S_END = CW'(OSR);

  logic [CW-1:0] taken;
  logic [CW-1:0] nidx;
  logic [2:0]    win;

  assign nidx = taken + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= '0;
      win   <= '0;
    end else if (clr) begin
      taken <= '0;
      win   <= '0;
    end else if (tick) begin
      if (!busy) begin
        taken <= start_det ? CW'(1) : '0;
      end else if (nidx == S_END) begin
        taken <= '0;
      end else begin
        taken <= nidx;
      end
      if (busy && nidx == S_LO)  win[0] <= line;
      if (busy && nidx == S_MID) win[1] <= line;
      if (busy && nidx == S_HI)  win[2] <= line;
    end
  end

  assign bit_end   = tick & busy & (nidx == S_END);
  assign bit_val   = vote3(win[0], win[1], win[2]);
  assign bit_noisy = split3(win[0], win[1], win[2]);

endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              line,
  input  logic              len9,
  input  logic              bit_end,
  input  logic              bit_val,
  input  logic              bit_noisy,
  output logic              busy,
  output logic              start_det,
  output logic              false_start,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_b8,
  output logic              char_noise,
  output logic              char_ferr
);

  localparam int SH_W = DATA_W + 1;
  localparam int IW   = $clog2(SH_W + 1);
  localparam logic [IW-1:0] N_WIDE  = IW'(SH_W);
  localparam logic [IW-1:0] N_NARROW = IW'(DATA_W);

  rx_phase_t       phase;
  logic [SH_W-1:0] sh;
  logic [IW-1:0]   idx;
  logic            wide;
  logic            acc;

  assign busy        = (phase != PH_IDLE);
  assign start_det   = tick & (phase == PH_IDLE) & ~line;
  assign false_start = bit_end & (phase == PH_START) & bit_val;
  assign char_done   = bit_end & (phase == PH_STOP);
  assign char_data   = wide ? sh[DATA_W-1:0] : sh[SH_W-1:1];
  assign char_b8     = wide & sh[SH_W-1];
  assign char_noise  = acc | bit_noisy;
  assign char_ferr   = ~bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sh    <= '0;
      idx   <= '0;
      wide  <= 1'b0;
      acc   <= 1'b0;
    end else if (clr) begin
      phase <= PH_IDLE;
      sh    <= '0;
      idx   <= '0;
      wide  <= 1'b0;
      acc   <= 1'b0;
    end else if (start_det) begin
      phase <= PH_START;
      wide  <= len9;
    end else if (bit_end) begin
      unique case (phase)
        PH_START: begin
          if (bit_val) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_DATA;
            idx   <= '0;
            acc   <= bit_noisy;
          end
        end
        PH_DATA: begin
          sh  <= {bit_val, sh[SH_W-1:1]};
          idx <= idx + IW'(1);
          acc <= acc | bit_noisy;
          if ((idx + IW'(1)) == (wide ? N_WIDE : N_NARROW)) phase <= PH_STOP;
        end
        PH_STOP: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_b8,
  input  logic              char_noise,
  input  logic              char_ferr,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              rx_noise,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              clear_evt
);

  logic armed;

  assign clear_evt = data_rd & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_bit8  <= 1'b0;
      rx_full  <= 1'b0;
      rx_noise <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
      armed    <= 1'b0;
    end else if (clr) begin
      rx_data  <= '0;
      rx_bit8  <= 1'b0;
      rx_full  <= 1'b0;
      rx_noise <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (char_done) begin
        if (rx_full && !clear_evt) begin
          rx_ovr <= 1'b1;
        end else begin
          rx_data  <= char_data;
          rx_bit8  <= char_b8;
          rx_full  <= 1'b1;
          rx_noise <= char_noise;
          rx_ferr  <= char_ferr;
          rx_ovr   <= 1'b0;
        end
      end else if (clear_evt) begin
        rx_full  <= 1'b0;
        rx_noise <= 1'b0;
        rx_ferr  <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (data_rd)      armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int MID    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tick16,
  input  logic              rx_line,
  input  logic              len9,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              rx_noise,
  output logic              rx_ferr,
  output logic              rx_ovr,
  output logic              rx_irq
);

  // internal events, named for the checker
  logic              clr;
  logic              busy;
  logic              start_det;
  logic              bit_end;
  logic              bit_val;
  logic              bit_noisy;
  logic              false_start;
  logic              char_done;
  logic [DATA_W-1:0] char_data;
  logic              char_b8;
  logic              char_noise;
  logic              char_ferr;
  logic              clear_evt;

  assign clr = ~rx_en;

  uart_os_rx_sampler #(.OSR(OSR), .MID(MID)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .tick      (tick16),
    .line      (rx_line),
    .busy      (busy),
    .start_det (start_det),
    .bit_end   (bit_end),
    .bit_val   (bit_val),
    .bit_noisy (bit_noisy)
  );

  uart_os_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .tick        (tick16),
    .line        (rx_line),
    .len9        (len9),
    .bit_end     (bit_end),
    .bit_val     (bit_val),
    .bit_noisy   (bit_noisy),
    .busy        (busy),
    .start_det   (start_det),
    .false_start (false_start),
    .char_done   (char_done),
    .char_data   (char_data),
    .char_b8     (char_b8),
    .char_noise  (char_noise),
    .char_ferr   (char_ferr)
  );

  uart_os_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .char_done  (char_done),
    .char_data  (char_data),
    .char_b8    (char_b8),
    .char_noise (char_noise),
    .char_ferr  (char_ferr),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .rx_bit8    (rx_bit8),
    .rx_full    (rx_full),
    .rx_noise   (rx_noise),
    .rx_ferr    (rx_ferr),
    .rx_ovr     (rx_ovr),
    .clear_evt  (clear_evt)
  );

  assign rx_irq = rx_full & irq_en;

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              tick16,
  input logic              irq_en,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_noise,
  input logic              rx_ferr,
  input logic              rx_ovr,
  input logic              rx_irq,
  input logic              char_done,
  input logic              false_start,
  input logic              clear_evt
);

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> (tick16 && rx_en)); // R4

  AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_full); // R3

  AST_FULL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(char_done)); // R3

  AST_NOISE_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_noise) |-> $past(char_done)); // R6

  AST_FALSE_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (false_start && !clear_evt) |=> ($stable(rx_full) && $stable(rx_data))); // R7

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full && !clear_evt) |=> (rx_ovr && $stable(rx_data))); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !char_done) |=> (!rx_full && !rx_ovr && !rx_noise && !rx_ferr)); // R10

  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && irq_en)); // R11

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_full && !rx_noise && !rx_ferr && !rx_ovr)); // R12

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .tick16      (tick16),
  .irq_en      (irq_en),
  .rx_data     (rx_data),
  .rx_full     (rx_full),
  .rx_noise    (rx_noise),
  .rx_ferr     (rx_ferr),
  .rx_ovr      (rx_ovr),
  .rx_irq      (rx_irq),
  .char_done   (char_done),
  .false_start (false_start),
  .clear_evt   (clear_evt)
);

// File: tb/uart_os_rx_bench.sv
`timescale 1ns/1ps
module uart_os_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_line = 1'b1;
  logic       len9 = 1'b0;
  logic       irq_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, rx_noise, rx_ferr, rx_ovr, rx_irq;

  int checks = 0;
  int errors = 0;
  bit rd_pend = 1'b0;

  always #4 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rx_line(rx_line),
    .len9(len9), .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full), .rx_noise(rx_noise),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_phase = 0;      // 0 hunt, 1 start, 2 data, 3 stop
  int m_samp[$];
  int m_bit, m_val, m_len9, m_acc;
  int e_data = 0, e_b8 = 0, e_full = 0, e_noise = 0, e_fe = 0, e_ovr = 0, e_armed = 0;

  always @(posedge clk) begin
    int ones, v, nz, done, fev, clr;
    done = 0; fev = 0;
    if (!rst_n || !rx_en) begin
      m_phase = 0; m_samp.delete(); m_acc = 0;
      e_data = 0; e_b8 = 0; e_full = 0; e_noise = 0; e_fe = 0; e_ovr = 0; e_armed = 0;
    end else begin
      if (tick16) begin
        if (m_phase == 0) begin
          if (rx_line == 1'b0) begin
            m_phase = 1; m_samp.delete(); m_samp.push_back(0); m_len9 = int'(len9);
          end
        end else begin
          m_samp.push_back(int'(rx_line));
          if (m_samp.size() == 16) begin
            ones = m_samp[7] + m_samp[8] + m_samp[9];
            v  = (ones >= 2) ? 1 : 0;
            nz = (ones == 1 || ones == 2) ? 1 : 0;
            m_samp.delete();
            if (m_phase == 1) begin
              if (v == 1) m_phase = 0;
              else begin m_phase = 2; m_bit = 0; m_val = 0; m_acc = nz; end
            end else if (m_phase == 2) begin
              m_val = m_val | (v << m_bit);
              m_bit++;
              m_acc = m_acc | nz;
              if (m_bit == (m_len9 ? 9 : 8)) m_phase = 3;
            end else begin
              m_acc = m_acc | nz; done = 1; fev = 1 - v; m_phase = 0;
            end
          end
        end
      end
      clr = (data_rd && e_armed) ? 1 : 0;
      if (done) begin
        if (e_full && !clr) e_ovr = 1;
        else begin
          e_data = m_val & 255; e_b8 = m_len9 ? ((m_val >> 8) & 1) : 0;
          e_full = 1; e_noise = m_acc; e_fe = fev; e_ovr = 0;
        end
      end else if (clr) begin
        e_full = 0; e_noise = 0; e_fe = 0; e_ovr = 0;
      end
      if (data_rd) e_armed = 0;
      else if (stat_rd) e_armed = 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit bad;
    if (rst_n) begin
      bad = 1'b0;
      checks++;
      if (int'(rx_data) != e_data) begin bad = 1; $display("FAIL R3 rx_data act=%0d exp=%0d", rx_data, e_data); end
      if (int'(rx_bit8) != e_b8)   begin bad = 1; $display("FAIL R2 rx_bit8 act=%0d exp=%0d", rx_bit8, e_b8); end
      if (int'(rx_full) != e_full) begin bad = 1; $display("FAIL R3 rx_full act=%0d exp=%0d", rx_full, e_full); end
      if (int'(rx_noise) != e_noise) begin bad = 1; $display("FAIL R5 rx_noise act=%0d exp=%0d", rx_noise, e_noise); end
      if (int'(rx_ferr) != e_fe)   begin bad = 1; $display("FAIL R8 rx_ferr act=%0d exp=%0d", rx_ferr, e_fe); end
      if (int'(rx_ovr) != e_ovr)   begin bad = 1; $display("FAIL R9 rx_ovr act=%0d exp=%0d", rx_ovr, e_ovr); end
      if (int'(rx_irq) != (e_full & int'(irq_en))) begin
        bad = 1; $display("FAIL R11 rx_irq act=%0d exp=%0d", rx_irq, e_full & int'(irq_en));
      end
      if (bad) errors++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(input logic v);
    rx_line = v; tick16 = 1'b1; data_rd = rd_pend;
    @(negedge clk);
    tick16 = 1'b0; data_rd = 1'b0; rd_pend = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tk(1'b1);
  endtask

  // nb data bits; flip sample fs of bit fb (0 start, 1..nb data, nb+1 stop)
  task automatic send(input int val, input int nb, input logic stopv,
                      input int fb, input int fs, input bit rd_last);
    for (int k = 0; k <= nb + 1; k++) begin
      for (int s = 1; s <= 16; s++) begin
        logic v;
        if (k == 0) v = 1'b0;
        else if (k == nb + 1) v = stopv;
        else v = logic'((val >> (k - 1)) & 1);
        if (k == fb && s == fs) v = ~v;
        if (rd_last && k == nb + 1 && s == 16) rd_pend = 1'b1;
        tk(v);
      end
    end
    idle(2);
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset full", int'(rx_full), 0);
    chk("R12 reset data", int'(rx_data), 0);
    rx_en = 1'b1; irq_en = 1'b1;
    idle(4);

    // R1 R4: clean 8-bit character
    send(8'hA5, 8, 1'b1, -1, 0, 0);
    chk("R1 data 8-bit", int'(rx_data), 8'hA5);
    chk("R3 full set", int'(rx_full), 1);
    chk("R2 bit8 zero in 8-bit mode", int'(rx_bit8), 0);
    chk("R11 irq raised", int'(rx_irq), 1);

    // R10: data read without status read has no effect
    pulse_data();
    chk("R10 lone data read keeps full", int'(rx_full), 1);
    pulse_stat(); pulse_data();
    chk("R10 status then data clears", int'(rx_full), 0);
    chk("R11 irq drops", int'(rx_irq), 0);

    // R4: glitch outside the vote window is ignored
    send(8'h96, 8, 1'b1, 2, 3, 0);
    chk("R4 glitch off-window data", int'(rx_data), 8'h96);
    chk("R4 glitch off-window no noise", int'(rx_noise), 0);
    pulse_stat(); pulse_data();

    // R5 R6: glitch at sample 9 of data bit 3
    send(8'h5A, 8, 1'b1, 3, 9, 0);
    chk("R5 noise flagged", int'(rx_noise), 1);
    chk("R5 majority keeps data", int'(rx_data), 8'h5A);
    pulse_stat(); pulse_data();

    // R1 R2: 9-bit character
    len9 = 1'b1;
    send(9'h1C3, 9, 1'b1, -1, 0, 0);
    len9 = 1'b0;
    chk("R1 data 9-bit", int'(rx_data), 8'hC3);
    chk("R2 ninth bit", int'(rx_bit8), 1);
    pulse_stat(); pulse_data();

    // R8: low stop bit
    send(8'h3C, 8, 1'b0, -1, 0, 0);
    chk("R8 framing error", int'(rx_ferr), 1);
    pulse_stat(); pulse_data();

    // R7: short low pulse is a false start
    for (int i = 0; i < 5; i++) tk(1'b0);
    idle(30);
    chk("R7 false start leaves empty", int'(rx_full), 0);

    // R9: second character without a read
    send(8'h11, 8, 1'b1, -1, 0, 0);
    send(8'h22, 8, 1'b1, -1, 0, 0);
    chk("R9 overrun set", int'(rx_ovr), 1);
    chk("R9 first data kept", int'(rx_data), 8'h11);

    // R10: clearing read coincides with completion
    pulse_stat();
    send(8'h33, 8, 1'b1, -1, 0, 1);
    chk("R10 coincident load data", int'(rx_data), 8'h33);
    chk("R10 coincident full", int'(rx_full), 1);
    chk("R10 coincident overrun cleared", int'(rx_ovr), 0);

    // R11: interrupt gated by enable
    irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irq masked", int'(rx_irq), 0);
    irq_en = 1'b1;

    // R12: disabled receiver
    rx_en = 1'b0;
    @(negedge clk);
    chk("R12 disable clears full", int'(rx_full), 0);
    send(8'h77, 8, 1'b1, -1, 0, 0);
    chk("R12 line ignored", int'(rx_full), 0);
    chk("R12 data cleared", int'(rx_data), 0);
    rx_en = 1'b1;
    idle(3);
    send(8'h0F, 8, 1'b1, -1, 0, 0);
    chk("R12 receives after re-enable", int'(rx_data), 8'h0F);

    idle(2);
    summary();
    $finish;
  end

endmodule